// File: doc/BRIEF.md
# Power Event Time Stamp Recorder

This block records when supply switchovers happen. It watches two single-cycle event pulses from the supply switchover logic. One pulse marks the move from main supply to backup, and the other marks the return to main. On each pulse the block copies the live calendar word (seconds, minutes, hours, day, month and year, packed into one vector) into a stamp register. The power-down stamp holds only the first outage since the last clear. The power-up stamp is replaced on every return, so it always shows the latest one.

Software reads both stamps, and a status word, through a small address-selected read port. A stamp-clear strobe empties both stamps and arms first-event capture again. A separate clock-failure flag is set when the block comes up cold after losing every supply. The flag stays set until software clears it with its own strobe.

Top module: `pwr_evt_stamp`

## Requirements
- R1: After reset, both stamps read as zero, the status word reads zero and `fail_o` is 0.
- R2: A `down_evt_i` pulse while the power-down stamp is empty loads `time_i` into it. The stamp and its occupied bit (status bit 0) are visible from the next cycle.
- R3: A `down_evt_i` pulse while the power-down stamp is occupied is ignored. The earliest stamp is kept.
- R4: Every `up_evt_i` pulse overwrites the power-up stamp with `time_i` and sets its occupied bit (status bit 1) from the next cycle.
- R5: A `clr_stamp_i` pulse with no event in the same cycle zeroes both stamps and both occupied bits in the next cycle.
- R6: When `clr_stamp_i` and `down_evt_i` arrive in the same cycle, the clear is applied first. The event is then captured, so the power-down stamp holds that cycle's `time_i`.
- R7: When `clr_stamp_i` and `up_evt_i` arrive in the same cycle, the power-up stamp holds that cycle's `time_i` and stays occupied.
- R8: `cold_start_i` high sets `fail_o` (also status bit 2) in the next cycle. The flag then stays set while `clr_fail_i` is low.
- R9: `clr_fail_i` clears `fail_o` in the next cycle, unless `cold_start_i` is high in the same cycle, in which case the flag stays set.
- R10: The read port is combinational. Address 0 returns the power-down stamp, 1 the power-up stamp, 2 the status word {fail, up occupied, down occupied} in bits 2:0 with zeros above, and 3 returns zero.
- R11: `clr_stamp_i` has no effect on `fail_o`, and `clr_fail_i` has no effect on either stamp.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| down_evt_i | input | 1 | Main-to-backup switchover pulse |
| up_evt_i | input | 1 | Backup-to-main switchover pulse |
| time_i | input | TIME_W (33) | Live packed calendar word |
| clr_stamp_i | input | 1 | Clears both stamps and re-arms first capture |
| cold_start_i | input | 1 | Start-up after loss of all supplies |
| clr_fail_i | input | 1 | Clears the clock-failure flag |
| rd_addr_i | input | 2 | Read register select |
| rd_data_o | output | TIME_W (33) | Selected register contents |
| fail_o | output | 1 | Clock-failure flag |

## Verification
The bound checker checks the following on every cycle:
- the keep-first rule of the power-down stamp, and the overwrite rule of the power-up stamp;
- the order of clear and event when both arrive in the same cycle;
- that the failure flag sets and holds, that cold start wins over its clear, and that the two clears stay independent;
- the read address map.

Some behaviours show only in the bench's scenarios. Among them are which of several outages survives a long sequence of pulses, and whether a value read back after many cycles is the one captured earlier. The bench compares every address against its reference model after each clock.

// File: rtl/pwr_evt_stamp_pkg.sv
package pwr_evt_stamp_pkg;

  parameter int YEAR_W = 7;

  typedef struct packed {
    logic [YEAR_W-1:0] year;
    logic [3:0]        month;
    logic [4:0]        day;
    logic [4:0]        hour;
    logic [5:0]        minute;
    logic [5:0]        second;
  } cal_time_t;

  localparam int TIME_W = $bits(cal_time_t);

  typedef enum logic [1:0] {
    RD_DOWN   = 2'd0,
    RD_UP     = 2'd1,
    RD_STATUS = 2'd2,
    RD_NONE   = 2'd3
  } rd_sel_e;

  typedef enum logic {
    KEEP_FIRST = 1'b0,
    KEEP_LAST  = 1'b1
  } keep_pol_e;

  localparam int STATUS_W = 3;

endpackage

// File: rtl/pwr_stamp_slot.sv
module pwr_stamp_slot
  import pwr_evt_stamp_pkg::*;
#(
  parameter int        W      = TIME_W,
  parameter keep_pol_e POLICY = KEEP_FIRST
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         evt_i,
  input  logic         clr_i,
  input  logic [W-1:0] time_i,
  output logic [W-1:0] stamp_o,
  output logic         vld_o
);

  logic [W-1:0] stamp_q;
  logic         vld_q;
  logic         load;

  // clear is ordered before capture, so a same-cycle event still lands
  generate
    if (POLICY == KEEP_FIRST) begin : g_first
      assign load = evt_i & (clr_i | ~vld_q);
    end else begin : g_last
      assign load = evt_i;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stamp_q <= '0;
      vld_q   <= 1'b0;
    end else begin
      if (load)       stamp_q <= time_i;
      else if (clr_i) stamp_q <= '0;
      vld_q <= load | (vld_q & ~clr_i);
    end
  end

  assign stamp_o = stamp_q;
  assign vld_o   = vld_q;

endmodule

// File: rtl/pwr_fail_flag.sv
module pwr_fail_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  logic flag_q;

  // set dominates: a cold start seen during a clear must not be lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= set_i | (flag_q & ~clr_i);
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/pwr_rd_mux.sv
module pwr_rd_mux
  import pwr_evt_stamp_pkg::*;
#(
  parameter int W = TIME_W
) (
  input  logic [1:0]          addr_i,
  input  logic [W-1:0]        down_i,
  input  logic [W-1:0]        up_i,
  input  logic [STATUS_W-1:0] status_i,
  output logic [W-1:0]        data_o
);

  localparam int PAD_W = W - STATUS_W;

  always_comb begin
    unique case (rd_sel_e'(addr_i))
      RD_DOWN:   data_o = down_i;
      RD_UP:     data_o = up_i;
      RD_STATUS: data_o = {{PAD_W{1'b0}}, status_i};
      default:   data_o = '0;
    endcase
  end

endmodule

// File: rtl/pwr_evt_stamp.sv
module pwr_evt_stamp
  import pwr_evt_stamp_pkg::*;
#(
  parameter int W = TIME_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         down_evt_i,
  input  logic         up_evt_i,
  input  logic [W-1:0] time_i,
  input  logic         clr_stamp_i,
  input  logic         cold_start_i,
  input  logic         clr_fail_i,
  input  logic [1:0]   rd_addr_i,
  output logic [W-1:0] rd_data_o,
  output logic         fail_o
);

  logic [W-1:0] down_q, up_q;
  logic         down_vld, up_vld, fail_q;

  pwr_stamp_slot #(.W(W), .POLICY(KEEP_FIRST)) u_down (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .evt_i   (down_evt_i),
    .clr_i   (clr_stamp_i),
    .time_i  (time_i),
    .stamp_o (down_q),
    .vld_o   (down_vld)
  );

  pwr_stamp_slot #(.W(W), .POLICY(KEEP_LAST)) u_up (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .evt_i   (up_evt_i),
    .clr_i   (clr_stamp_i),
    .time_i  (time_i),
    .stamp_o (up_q),
    .vld_o   (up_vld)
  );

  pwr_fail_flag u_fail (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (cold_start_i),
    .clr_i  (clr_fail_i),
    .flag_o (fail_q)
  );

  pwr_rd_mux #(.W(W)) u_rd (
    .addr_i   (rd_addr_i),
    .down_i   (down_q),
    .up_i     (up_q),
    .status_i ({fail_q, up_vld, down_vld}),
    .data_o   (rd_data_o)
  );

  assign fail_o = fail_q;

endmodule

// File: rtl/pwr_evt_stamp_chk.sv
module pwr_evt_stamp_chk #(
  parameter int W = 33
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         down_evt_i,
  input logic         up_evt_i,
  input logic [W-1:0] time_i,
  input logic         clr_stamp_i,
  input logic         cold_start_i,
  input logic         clr_fail_i,
  input logic [1:0]   rd_addr_i,
  input logic [W-1:0] rd_data_o,
  input logic         fail_o,
  input logic [W-1:0] down_q,
  input logic [W-1:0] up_q,
  input logic         down_vld,
  input logic         up_vld
);

  // R2
  first_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (down_evt_i && !down_vld && !clr_stamp_i) |=> (down_vld && down_q == $past(time_i)));

  // R3
  keep_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (down_vld && !clr_stamp_i) |=> (down_vld && down_q == $past(down_q)));

  // R4
  keep_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_evt_i |=> (up_vld && up_q == $past(time_i)));

  // R5
  clr_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_stamp_i && !down_evt_i) |=> (!down_vld && down_q == '0));

  // R5
  clr_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_stamp_i && !up_evt_i) |=> (!up_vld && up_q == '0));

  // R6
  clr_then_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_stamp_i && down_evt_i) |=> (down_vld && down_q == $past(time_i)));

  // R8
  fail_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cold_start_i |=> fail_o);

  // R8
  fail_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_o && !clr_fail_i) |=> fail_o);

  // R9
  fail_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_fail_i && !cold_start_i) |=> !fail_o);

  // R11
  fail_indep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cold_start_i && !clr_fail_i) |=> $stable(fail_o));

  // R10
  rd_map_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o == ((rd_addr_i == 2'd0) ? down_q :
                  (rd_addr_i == 2'd1) ? up_q :
                  (rd_addr_i == 2'd2) ? {{(W-3){1'b0}}, fail_o, up_vld, down_vld} :
                  {W{1'b0}}));

endmodule

bind pwr_evt_stamp pwr_evt_stamp_chk #(.W(W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .down_evt_i   (down_evt_i),
  .up_evt_i     (up_evt_i),
  .time_i       (time_i),
  .clr_stamp_i  (clr_stamp_i),
  .cold_start_i (cold_start_i),
  .clr_fail_i   (clr_fail_i),
  .rd_addr_i    (rd_addr_i),
  .rd_data_o    (rd_data_o),
  .fail_o       (fail_o),
  .down_q       (down_q),
  .up_q         (up_q),
  .down_vld     (down_vld),
  .up_vld       (up_vld)
);

// File: tb/pwr_evt_stamp_tb.sv
`timescale 1ns/100ps
module pwr_evt_stamp_tb;
  import pwr_evt_stamp_pkg::*;

  localparam int W = TIME_W;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         down_evt = 1'b0, up_evt = 1'b0, clr_stamp = 1'b0;
  logic         cold_start = 1'b0, clr_fail = 1'b0;
  logic [W-1:0] time_v = '0;
  logic [1:0]   rd_addr = 2'd0;
  logic [W-1:0] rd_data;
  logic         fail;

  int    total = 0;
  int    bad = 0;
  string tag = "R1";
  bit    done = 1'b0;

  logic [W-1:0] m_down, m_up;
  bit           m_dv, m_uv, m_fail;
  logic [W-1:0] seed = 33'h1_2345_6789;

  always #4 clk = ~clk;

  pwr_evt_stamp u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .down_evt_i   (down_evt),
    .up_evt_i     (up_evt),
    .time_i       (time_v),
    .clr_stamp_i  (clr_stamp),
    .cold_start_i (cold_start),
    .clr_fail_i   (clr_fail),
    .rd_addr_i    (rd_addr),
    .rd_data_o    (rd_data),
    .fail_o       (fail)
  );

  // behavioural reference
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_down = '0; m_up = '0; m_dv = 0; m_uv = 0; m_fail = 0;
    end else begin
      if (clr_stamp) begin
        m_down = '0; m_up = '0; m_dv = 0; m_uv = 0;
      end
      if (down_evt && !m_dv) begin m_down = time_v; m_dv = 1; end
      if (up_evt) begin m_up = time_v; m_uv = 1; end
      if (cold_start) m_fail = 1;
      else if (clr_fail) m_fail = 0;
    end
  end

  function automatic logic [W-1:0] exp_rd(int a);
    case (a)
      0: return m_down;
      1: return m_up;
      2: return W'({m_fail, m_uv, m_dv});
      default: return '0;
    endcase
  endfunction

  task automatic check(string req, string what, logic [W-1:0] got, logic [W-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  task automatic read(int a, output logic [W-1:0] v);
    rd_addr = 2'(a);
    #0.5;
    v = rd_data;
  endtask

  // per-cycle comparison of every address against the model
  task automatic sweep();
    logic [W-1:0] v;
    for (int a = 0; a < 4; a++) begin
      read(a, v);
      check((a == 3) ? "R10" : tag, $sformatf("addr%0d", a), v, exp_rd(a));
    end
    check(tag, "fail_o", W'(fail), W'(m_fail));
  endtask

  task automatic step(bit dn, bit up, bit clr, bit cold, bit cf);
    seed = seed * 33'd1103515245 + 33'd12345;
    time_v = seed;
    down_evt = dn; up_evt = up; clr_stamp = clr;
    cold_start = cold; clr_fail = cf;
    @(posedge clk);
    #1;
    sweep();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] t_first, t_last, v;
    repeat (3) @(posedge clk);
    #1;
    tag = "R1";
    sweep();
    rst_n = 1'b1;
    step(0,0,0,0,0);
    read(0, v); check("R1", "down after reset", v, '0);
    read(2, v); check("R1", "status after reset", v, '0);

    tag = "R2";
    step(1,0,0,0,0); t_first = time_v;
    read(0, v); check("R2", "first down stamp", v, t_first);
    read(2, v); check("R2", "down occupied", W'(v[0]), W'(1));

    tag = "R3";
    step(0,0,0,0,0);
    step(1,0,0,0,0);
    step(1,0,0,0,0);
    read(0, v); check("R3", "earliest kept", v, t_first);

    tag = "R4";
    step(0,1,0,0,0);
    step(0,1,0,0,0); t_last = time_v;
    step(0,0,0,0,0);
    read(1, v); check("R4", "latest up stamp", v, t_last);

    tag = "R5";
    step(0,0,1,0,0);
    read(0, v); check("R5", "down cleared", v, '0);
    read(1, v); check("R5", "up cleared", v, '0);
    read(2, v); check("R5", "status cleared", v, '0);

    tag = "R6";
    step(1,0,0,0,0);
    step(1,0,1,0,0); t_first = time_v;
    read(0, v); check("R6", "clear then capture", v, t_first);

    tag = "R7";
    step(0,1,1,0,0); t_last = time_v;
    read(1, v); check("R7", "clear with up", v, t_last);
    read(2, v); check("R7", "up occupied", W'(v[1]), W'(1));

    tag = "R8";
    step(0,0,0,1,0);
    check("R8", "fail set", W'(fail), W'(1));
    for (int i = 0; i < 5; i++) step(0,0,0,0,0);
    read(2, v); check("R8", "fail held", W'(v[2]), W'(1));

    tag = "R11";
    step(0,0,1,0,0);
    check("R11", "stamp clear keeps fail", W'(fail), W'(1));
    step(0,1,0,0,0); t_last = time_v;
    step(0,0,0,0,1);
    read(1, v); check("R11", "fail clear keeps stamp", v, t_last);

    tag = "R9";
    check("R9", "fail cleared", W'(fail), W'(0));
    step(0,0,0,1,0);
    step(0,0,0,1,1);
    check("R9", "cold beats clear", W'(fail), W'(1));
    step(0,0,0,0,1);
    check("R9", "fail cleared again", W'(fail), W'(0));

    tag = "R10";
    for (int i = 0; i < 40; i++)
      step(bit'(i % 7 == 2), bit'(i % 5 == 1), bit'(i % 11 == 6),
           bit'(i % 13 == 4), bit'(i % 9 == 3));

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule